// File: doc/BRIEF.md
# Two-Bank Fast/Normal Interrupt Controller

This block gathers forty level-sensitive interrupt lines and presents them to a processor core as two request outputs: a fast request and a normal request. Each line has an enable bit and a fast-select bit. An enabled, pending line whose fast-select bit is set drives the fast request. An enabled, pending line whose fast-select bit is clear drives the normal request. The per-line state is held as two 32-bit banks. Lines 0 to 31 live in bank 0, and lines 32 to 39 occupy the low bits of bank 1.

While the core reports that it is halted, the block also raises a wake request. A line raises it when it is pending and either enabled or covered by a single shared idle-enable word. Every line carries a software priority. A status word names the best active fast line and the best active normal line.

Software reaches the same storage through two ports. One is a word-wide memory-mapped port addressed by byte offset. The other is a coprocessor-style port addressed by a small register number.

Top module: `dual_bank_intc`

## Requirements
- R1: Line n (n < 32) is bit n of bank 0, and line n (32 ≤ n < 40) is bit n-32 of bank 1. Bank 1 bits 8 to 31 always read zero, and writes to them are dropped.
- R2: The raw pending word of each bank follows the line levels, sampled at every clock edge. It is cleared by reset and is not writable.
- R3: `fiq_req` is high when some line is pending, enabled and fast-selected. `irq_req` is high when some line is pending, enabled and not fast-selected. Both are registered: they follow a register write one clock after it commits, and they follow a line level two clocks after it is sampled.
- R4: The normal-pending view of a bank reads pending & enable & ~fast. The fast-pending view reads pending & enable & fast.
- R5: `wake_req` is high (registered, one clock later) only while `core_halted` is high and some line is pending and covered by its enable bit OR'ed with the idle-enable word. Idle-enable bit i covers both line i and line 32+i.
- R6: The register map is shared by both ports.
  - Coprocessor index k (0 to 10) and memory byte offset 4·k select the same register: 0 normal-pending b0, 1 enable b0, 2 fast-select b0, 3 fast-pending b0, 4 raw pending b0, 5 best-source, 6 normal-pending b1, 7 enable b1, 8 fast-select b1, 9 fast-pending b1, 10 raw pending b1.
  - The idle-enable word is at memory offset 0x30.
- R7: Best-source word layout:
  - bits [5:0] hold the best active fast line and bit 15 is its valid flag.
  - bits [21:16] hold the best active normal line and bit 31 is its valid flag.
  - "Best" means the lowest priority value, with the lower line number winning ties.
  - Each valid flag is clear, with its number field zero, when no such line is active.
- R8: Each line's 6-bit priority sits at memory offset 0x100+4·n and is readable and writable. Bits above 5 read zero.
- R9: Reset clears pending, enable, fast-select, idle-enable and all priorities, and drives all three request outputs low.
- R10: Reads of unmapped coprocessor indices (11 to 15), unmapped or misaligned memory offsets, and priority slots 40 and above return zero. Writes to them, or to read-only registers, change nothing.
- R11: If both ports write the same register in one cycle, the memory port's value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_level | input | 40 | Interrupt line levels |
| core_halted | input | 1 | Core is in its halted state |
| mem_we | input | 1 | Memory port write strobe |
| mem_addr | input | 12 | Memory port byte offset |
| mem_wdata | input | 32 | Memory port write data |
| mem_rdata | output | 32 | Memory port read data (combinational) |
| cp_we | input | 1 | Coprocessor port write strobe |
| cp_idx | input | 4 | Coprocessor register number |
| cp_wdata | input | 32 | Coprocessor port write data |
| cp_rdata | output | 32 | Coprocessor port read data (combinational) |
| fiq_req | output | 1 | Fast interrupt request |
| irq_req | output | 1 | Normal interrupt request |
| wake_req | output | 1 | Wake request to a halted core |

## Verification
The hardest situation to reach from the ports is a wake request raised only through the idle-enable word for a bank-1 line. This needs a halted core, a line above 31 held high, its enable bit clear, and an idle bit at the line's position minus 32. The stimulus builds exactly that state and checks that `wake_req` rises while `irq_req` stays low. It then removes the halt and checks that `wake_req` drops one clock later. Priority ties and port collisions are produced with directed sequences: two equal priorities on active normal lines, and simultaneous writes from both ports to one enable word.

// File: rtl/dbi_pkg.sv
package dbi_pkg;

   typedef enum logic [3:0] {
      K_NONE, K_IRQP, K_EN, K_FSEL, K_FIQP, K_RAW, K_BEST, K_IDLE, K_PRIO
   } kind_e;

   typedef struct packed {
      kind_e kind;
      logic  bank;
   } slot_t;

   localparam logic [3:0] SLOT_LAST = 4'd10;

   // shared register-number order used by both ports
   function automatic slot_t slot_of_index(input logic [3:0] n);
      slot_t s;
      logic [3:0] k;
      s.kind = K_NONE;
      s.bank = 1'b0;
      k      = n;
      if (n >= 4'd6 && n <= SLOT_LAST) begin
         s.bank = 1'b1;
         k      = n - 4'd6;
      end
      if (n == 4'd5) begin
         s.kind = K_BEST;
      end else if (n <= SLOT_LAST) begin
         case (k)
            4'd0:    s.kind = K_IRQP;
            4'd1:    s.kind = K_EN;
            4'd2:    s.kind = K_FSEL;
            4'd3:    s.kind = K_FIQP;
            4'd4:    s.kind = K_RAW;
            default: s.kind = K_NONE;
         endcase
      end
      return s;
   endfunction

endpackage

// File: rtl/dbi_decode.sv
module dbi_decode
   import dbi_pkg::*;
#(
   parameter bit MEM_STYLE = 1'b1,
   parameter int ADDR_W    = 12,
   parameter int NUM_SRC   = 40,
   parameter int SRC_W     = 6
) (
   input  logic [ADDR_W-1:0] addr,
   output slot_t             slot,
   output logic [SRC_W-1:0]  pidx
);

   generate
      if (MEM_STYLE) begin : g_mem
         if (ADDR_W < 10) begin : g_bad_aw
            $error("dbi_decode: memory offset too narrow");
         end
         logic [ADDR_W-1:0] pw;
         always_comb begin
            slot.kind = K_NONE;
            slot.bank = 1'b0;
            pidx      = '0;
            pw        = (addr - ADDR_W'(256)) >> 2;
            if (addr[1:0] == 2'b00) begin
               if (addr < ADDR_W'(256)) begin
                  if (addr[7:2] <= 6'(SLOT_LAST)) begin
                     slot = slot_of_index(addr[5:2]);
                  end else if (addr[7:2] == 6'd12) begin
                     slot.kind = K_IDLE;
                  end
               end else if (pw < ADDR_W'(NUM_SRC)) begin
                  slot.kind = K_PRIO;
                  pidx      = SRC_W'(pw);
               end
            end
         end
      end else begin : g_cp
         if (ADDR_W != 4) begin : g_bad_cw
            $error("dbi_decode: register number must be 4 bits");
         end
         always_comb begin
            slot = slot_of_index(addr[3:0]);
            pidx = '0;
         end
      end
   endgenerate

endmodule

// File: rtl/dbi_pick.sv
module dbi_pick #(
   parameter int N      = 40,
   parameter int PRIO_W = 6,
   parameter int SRC_W  = 6
) (
   input  logic [N-1:0]        act,
   input  logic [N*PRIO_W-1:0] prio_flat,
   output logic                found,
   output logic [SRC_W-1:0]    who
);

   logic [PRIO_W-1:0] best;

   // lowest value wins; strict compare keeps the lower index on ties
   always_comb begin
      found = 1'b0;
      who   = '0;
      best  = '0;
      for (int i = 0; i < N; i++) begin
         if (act[i] && (!found || prio_flat[i*PRIO_W +: PRIO_W] < best)) begin
            found = 1'b1;
            best  = prio_flat[i*PRIO_W +: PRIO_W];
            who   = SRC_W'(i);
         end
      end
   end

endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
   import dbi_pkg::*;
#(
   parameter int NUM_SRC = 40,
   parameter int WORD_W  = 32,
   parameter int PRIO_W  = 6,
   parameter int MEM_AW  = 12,
   parameter int CP_AW   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_level,
   input  logic               core_halted,
   input  logic               mem_we,
   input  logic [MEM_AW-1:0]  mem_addr,
   input  logic [WORD_W-1:0]  mem_wdata,
   output logic [WORD_W-1:0]  mem_rdata,
   input  logic               cp_we,
   input  logic [CP_AW-1:0]   cp_idx,
   input  logic [WORD_W-1:0]  cp_wdata,
   output logic [WORD_W-1:0]  cp_rdata,
   output logic               fiq_req,
   output logic               irq_req,
   output logic               wake_req
);

   localparam int NBANK = (NUM_SRC + WORD_W - 1) / WORD_W;
   localparam int PADW  = NBANK * WORD_W;
   localparam int SRC_W = $clog2(NUM_SRC);

   generate
      if (WORD_W != 32) begin : g_bad_word
         $error("dual_bank_intc: word width must be 32");
      end
      if (NBANK != 2 || NUM_SRC >= PADW) begin : g_bad_src
         $error("dual_bank_intc: source count must be 33..63");
      end
      if (PRIO_W < 1 || PRIO_W > 15) begin : g_bad_prio
         $error("dual_bank_intc: priority width out of range");
      end
   endgenerate

   // ---------------- state ----------------
   logic [NUM_SRC-1:0] pend_q, en_q, fs_q, en_d, fs_d;
   logic [WORD_W-1:0]  idle_q, idle_d;
   logic [PRIO_W-1:0]  prio_q [NUM_SRC];
   logic [PRIO_W-1:0]  prio_d [NUM_SRC];
   logic               fiq_q, irq_q, wake_q;

   // ---------------- decode ----------------
   slot_t             cp_slot, mem_slot;
   logic [SRC_W-1:0]  cp_pidx, mem_pidx;

   dbi_decode #(.MEM_STYLE(1'b0), .ADDR_W(CP_AW), .NUM_SRC(NUM_SRC), .SRC_W(SRC_W))
      u_cp_dec (.addr(cp_idx), .slot(cp_slot), .pidx(cp_pidx));

   dbi_decode #(.MEM_STYLE(1'b1), .ADDR_W(MEM_AW), .NUM_SRC(NUM_SRC), .SRC_W(SRC_W))
      u_mem_dec (.addr(mem_addr), .slot(mem_slot), .pidx(mem_pidx));

   // ---------------- active sets ----------------
   logic [NUM_SRC-1:0] act, fact, iact;
   logic [PADW-1:0]    raw_p, en_p, fs_p, fact_p, iact_p, wake_cov;

   assign act    = pend_q & en_q;
   assign fact   = act & fs_q;
   assign iact   = act & ~fs_q;
   assign raw_p  = PADW'(pend_q);
   assign en_p   = PADW'(en_q);
   assign fs_p   = PADW'(fs_q);
   assign fact_p = PADW'(fact);
   assign iact_p = PADW'(iact);
   assign wake_cov = raw_p & (en_p | {NBANK{idle_q}});

   // ---------------- priority pick ----------------
   logic [NUM_SRC*PRIO_W-1:0] prio_flat;
   logic                      fiq_found, irq_found;
   logic [SRC_W-1:0]          fiq_who, irq_who;
   logic [WORD_W-1:0]         best_word;

   generate
      for (genvar g = 0; g < NUM_SRC; g++) begin : g_flat
         assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q[g];
      end
   endgenerate

   dbi_pick #(.N(NUM_SRC), .PRIO_W(PRIO_W), .SRC_W(SRC_W))
      u_pick_fiq (.act(fact), .prio_flat(prio_flat), .found(fiq_found), .who(fiq_who));

   dbi_pick #(.N(NUM_SRC), .PRIO_W(PRIO_W), .SRC_W(SRC_W))
      u_pick_irq (.act(iact), .prio_flat(prio_flat), .found(irq_found), .who(irq_who));

   always_comb begin
      best_word              = '0;
      best_word[SRC_W-1:0]   = fiq_who;
      best_word[15]          = fiq_found;
      best_word[16 +: SRC_W] = irq_who;
      best_word[31]          = irq_found;
   end

   // ---------------- read views ----------------
   function automatic logic [WORD_W-1:0] pick_bank(input logic [PADW-1:0] v,
                                                   input logic b);
      return b ? v[WORD_W +: WORD_W] : v[0 +: WORD_W];
   endfunction

   function automatic logic [WORD_W-1:0] view(input slot_t s,
                                              input logic [SRC_W-1:0] pi);
      case (s.kind)
         K_IRQP:  return pick_bank(iact_p, s.bank);
         K_FIQP:  return pick_bank(fact_p, s.bank);
         K_EN:    return pick_bank(en_p, s.bank);
         K_FSEL:  return pick_bank(fs_p, s.bank);
         K_RAW:   return pick_bank(raw_p, s.bank);
         K_BEST:  return best_word;
         K_IDLE:  return idle_q;
         K_PRIO:  return WORD_W'(prio_q[pi]);
         default: return '0;
      endcase
   endfunction

   assign cp_rdata  = view(cp_slot, cp_pidx);
   assign mem_rdata = view(mem_slot, mem_pidx);

   // ---------------- write path (index 1 = memory port, applied last) ----------------
   logic              wr_en   [2];
   slot_t             wr_slot [2];
   logic [WORD_W-1:0] wr_data [2];
   logic [SRC_W-1:0]  wr_pidx [2];

   assign wr_en[0]   = cp_we;
   assign wr_slot[0] = cp_slot;
   assign wr_data[0] = cp_wdata;
   assign wr_pidx[0] = cp_pidx;
   assign wr_en[1]   = mem_we;
   assign wr_slot[1] = mem_slot;
   assign wr_data[1] = mem_wdata;
   assign wr_pidx[1] = mem_pidx;

   function automatic logic [NUM_SRC-1:0] put_bank(input logic [NUM_SRC-1:0] v,
                                                   input logic b,
                                                   input logic [WORD_W-1:0] d);
      logic [PADW-1:0] t;
      t = PADW'(v);
      if (b) t[WORD_W +: WORD_W] = d;
      else   t[0 +: WORD_W]      = d;
      return t[NUM_SRC-1:0];
   endfunction

   always_comb begin
      en_d   = en_q;
      fs_d   = fs_q;
      idle_d = idle_q;
      prio_d = prio_q;
      for (int p = 0; p < 2; p++) begin
         if (wr_en[p]) begin
            case (wr_slot[p].kind)
               K_EN:    en_d   = put_bank(en_d, wr_slot[p].bank, wr_data[p]);
               K_FSEL:  fs_d   = put_bank(fs_d, wr_slot[p].bank, wr_data[p]);
               K_IDLE:  idle_d = wr_data[p];
               K_PRIO:  prio_d[wr_pidx[p]] = wr_data[p][PRIO_W-1:0];
               default: ;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         en_q   <= '0;
         fs_q   <= '0;
         idle_q <= '0;
         for (int i = 0; i < NUM_SRC; i++) prio_q[i] <= '0;
         fiq_q  <= 1'b0;
         irq_q  <= 1'b0;
         wake_q <= 1'b0;
      end else begin
         pend_q <= src_level;
         en_q   <= en_d;
         fs_q   <= fs_d;
         idle_q <= idle_d;
         prio_q <= prio_d;
         fiq_q  <= |fact;
         irq_q  <= |iact;
         wake_q <= core_halted & (|wake_cov);
      end
   end

   assign fiq_req  = fiq_q;
   assign irq_req  = irq_q;
   assign wake_req = wake_q;

endmodule

// File: rtl/dbi_checker.sv
module dbi_checker #(
   parameter int NUM_SRC = 40,
   parameter int WORD_W  = 32,
   parameter int CP_AW   = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] src_level,
   input logic               core_halted,
   input logic [CP_AW-1:0]   cp_idx,
   input logic [WORD_W-1:0]  cp_rdata,
   input logic               fiq_req,
   input logic               irq_req,
   input logic               wake_req
);

   // R3: no line high two samples back means no request now
   assert_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(src_level, 2) == '0) |-> (!fiq_req && !irq_req));

   // R5: wake only follows a halted core
   assert_wake_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(core_halted) |-> !wake_req);

   // R7: best-source valid flags agree with the request outputs one cycle on
   assert_best_fiq_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cp_idx) == CP_AW'(5)) |-> (fiq_req == $past(cp_rdata[15])));

   assert_best_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cp_idx) == CP_AW'(5)) |-> (irq_req == $past(cp_rdata[31])));

   // R4: a nonzero view leads to the matching request
   assert_irq_view_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_idx == CP_AW'(0) && cp_rdata != '0) |=> irq_req);

   assert_fiq_view_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_idx == CP_AW'(3) && cp_rdata != '0) |=> fiq_req);

   // R10: unmapped register numbers read zero
   assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_idx > CP_AW'(10)) |-> (cp_rdata == '0));

   // R1: unused bank-1 enable bits read zero
   assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_idx == CP_AW'(7)) |-> (cp_rdata[WORD_W-1:NUM_SRC-WORD_W] == '0));

endmodule

bind dual_bank_intc dbi_checker #(.NUM_SRC(NUM_SRC), .WORD_W(WORD_W), .CP_AW(CP_AW))
   u_chk (.clk(clk), .rst_n(rst_n), .src_level(src_level), .core_halted(core_halted),
          .cp_idx(cp_idx), .cp_rdata(cp_rdata), .fiq_req(fiq_req),
          .irq_req(irq_req), .wake_req(wake_req));

// File: tb/dual_bank_intc_test.sv
`timescale 1ns/1ps
module dual_bank_intc_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [39:0] src_level;
   logic        core_halted;
   logic        mem_we;
   logic [11:0] mem_addr;
   logic [31:0] mem_wdata, mem_rdata;
   logic        cp_we;
   logic [3:0]  cp_idx;
   logic [31:0] cp_wdata, cp_rdata;
   logic        fiq_req, irq_req, wake_req;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   dual_bank_intc uut (
      .clk(clk), .rst_n(rst_n), .src_level(src_level), .core_halted(core_halted),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .cp_we(cp_we), .cp_idx(cp_idx), .cp_wdata(cp_wdata), .cp_rdata(cp_rdata),
      .fiq_req(fiq_req), .irq_req(irq_req), .wake_req(wake_req));

   localparam logic [11:0] A_IRQP0 = 12'h000, A_EN0 = 12'h004, A_FS0 = 12'h008;
   localparam logic [11:0] A_RAW0  = 12'h010, A_EN1 = 12'h01C, A_FS1 = 12'h020;
   localparam logic [11:0] A_IDLE  = 12'h030, A_PRIO = 12'h100;

   // table: line levels, enables, fast selects, expected fast/normal requests
   localparam int NV = 7;
   localparam logic [39:0] V_SRC [NV] = '{40'h0, 40'h8, 40'h8, 40'h08_0000_0000,
      40'h08_0000_0004, 40'hFF_FFFF_FFFF, 40'h00_0000_0001};
   localparam logic [39:0] V_EN  [NV] = '{40'hFF_FFFF_FFFF, 40'h8, 40'h0, 40'h08_0000_0000,
      40'h08_0000_0004, 40'h80_0000_0000, 40'h80_0000_0001};
   localparam logic [39:0] V_FS  [NV] = '{40'h0, 40'h0, 40'h0, 40'h08_0000_0000,
      40'h08_0000_0000, 40'h0, 40'h80_0000_0000};
   localparam logic V_FIQ [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
   localparam logic V_IRQ [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic mem_wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      mem_addr = a; mem_wdata = d; mem_we = 1'b1;
      @(negedge clk);
      mem_we = 1'b0;
   endtask

   task automatic cp_wr(input logic [3:0] i, input logic [31:0] d);
      @(negedge clk);
      cp_idx = i; cp_wdata = d; cp_we = 1'b1;
      @(negedge clk);
      cp_we = 1'b0;
   endtask

   task automatic mem_rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      mem_addr = a;
      #1 d = mem_rdata;
   endtask

   task automatic cp_rd(input logic [3:0] i, output logic [31:0] d);
      @(negedge clk);
      cp_idx = i;
      #1 d = cp_rdata;
   endtask

   task automatic set_masks(input logic [39:0] en, input logic [39:0] fs);
      mem_wr(A_EN0, en[31:0]);
      mem_wr(A_EN1, {24'h0, en[39:32]});
      mem_wr(A_FS0, fs[31:0]);
      mem_wr(A_FS1, {24'h0, fs[39:32]});
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d, d2;
      logic [39:0] exp_i, exp_f;
      rst_n = 1'b0; src_level = '1; core_halted = 1'b0;
      mem_we = 1'b0; mem_addr = '0; mem_wdata = '0;
      cp_we = 1'b0; cp_idx = '0; cp_wdata = '0;
      repeat (3) @(posedge clk);

      // R9 / R2: reset state while lines are held high
      cp_rd(4'd4, d);  chk("R2 raw pending in reset", d, 32'h0);
      cp_rd(4'd1, d);  chk("R9 enable b0 reset", d, 32'h0);
      cp_rd(4'd8, d);  chk("R9 fast-select b1 reset", d, 32'h0);
      mem_rd(A_IDLE, d); chk("R9 idle reset", d, 32'h0);
      mem_rd(A_PRIO, d); chk("R9 priority reset", d, 32'h0);
      chk("R9 outputs reset", {29'h0, fiq_req, irq_req, wake_req}, 32'h0);
      @(negedge clk); src_level = '0; rst_n = 1'b1;

      // table walk: R3 outputs, R4 views, R1 bank placement
      for (int i = 0; i < NV; i++) begin
         set_masks(V_EN[i], V_FS[i]);
         @(negedge clk); src_level = V_SRC[i];
         settle();
         chk($sformatf("R3 vec%0d fiq", i), {31'h0, fiq_req}, {31'h0, V_FIQ[i]});
         chk($sformatf("R3 vec%0d irq", i), {31'h0, irq_req}, {31'h0, V_IRQ[i]});
         exp_i = V_SRC[i] & V_EN[i] & ~V_FS[i];
         exp_f = V_SRC[i] & V_EN[i] & V_FS[i];
         cp_rd(4'd0, d); chk($sformatf("R4 vec%0d irqp b0", i), d, exp_i[31:0]);
         cp_rd(4'd6, d); chk($sformatf("R1 vec%0d irqp b1", i), d, {24'h0, exp_i[39:32]});
         cp_rd(4'd3, d); chk($sformatf("R4 vec%0d fiqp b0", i), d, exp_f[31:0]);
         cp_rd(4'd9, d); chk($sformatf("R4 vec%0d fiqp b1", i), d, {24'h0, exp_f[39:32]});
         cp_rd(4'd10, d); chk($sformatf("R2 vec%0d raw b1", i), d, {24'h0, V_SRC[i][39:32]});
      end

      // R3 timing: line change shows two edges later
      set_masks(40'h20, 40'h0);
      @(negedge clk); src_level = 40'h0;
      settle();
      @(negedge clk); src_level = 40'h20;
      @(negedge clk); #1 chk("R3 irq not yet after one edge", {31'h0, irq_req}, 32'h0);
      @(negedge clk); #1 chk("R3 irq after two edges", {31'h0, irq_req}, 32'h1);
      // R3 timing: fast-select write shows one edge after commit
      mem_wr(A_FS0, 32'h20);
      #1 chk("R3 fiq unchanged at commit", {31'h0, fiq_req}, 32'h0);
      @(negedge clk); #1 chk("R3 fiq one edge after commit", {31'h0, fiq_req}, 32'h1);
      chk("R3 irq dropped with fast select", {31'h0, irq_req}, 32'h0);

      // R1: unused bank-1 bits
      cp_wr(4'd7, 32'hFFFF_FFFF);
      mem_rd(A_EN1, d); chk("R1 enable b1 upper bits", d, 32'h0000_00FF);

      // R6: both ports reach the same storage
      cp_wr(4'd1, 32'h1234_5678);
      mem_rd(A_EN0, d); chk("R6 cp write seen by memory port", d, 32'h1234_5678);
      mem_wr(A_FS1, 32'h0000_003C);
      cp_rd(4'd8, d); chk("R6 memory write seen by cp port", d, 32'h0000_003C);

      // R11: collision, memory port wins
      @(negedge clk);
      cp_idx = 4'd1; cp_wdata = 32'hAAAA_AAAA; cp_we = 1'b1;
      mem_addr = A_EN0; mem_wdata = 32'h5555_5555; mem_we = 1'b1;
      @(negedge clk); cp_we = 1'b0; mem_we = 1'b0;
      cp_rd(4'd1, d); chk("R11 memory port wins", d, 32'h5555_5555);

      // R2 / R10: read-only and unmapped writes
      @(negedge clk); src_level = '0;
      settle();
      mem_wr(A_RAW0, 32'hFFFF_FFFF);
      mem_rd(A_RAW0, d); chk("R2 raw pending not writable", d, 32'h0);
      mem_wr(A_IRQP0, 32'hFFFF_FFFF);
      mem_rd(A_IRQP0, d); chk("R10 normal view not writable", d, 32'h0);
      mem_rd(A_EN0, d2);
      mem_wr(12'h034, 32'h0);
      mem_rd(A_EN0, d); chk("R10 unmapped write leaves enable", d, d2);
      mem_rd(12'h034, d); chk("R10 unmapped memory read", d, 32'h0);
      mem_rd(12'h006, d); chk("R10 misaligned read", d, 32'h0);
      cp_rd(4'd11, d); chk("R10 unmapped cp index 11", d, 32'h0);
      cp_rd(4'd15, d); chk("R10 unmapped cp index 15", d, 32'h0);

      // R8: priority storage width and range
      mem_wr(A_PRIO + 12'd156, 32'hFFFF_FFFF);
      mem_rd(A_PRIO + 12'd156, d); chk("R8 priority 39 readback", d, 32'h0000_003F);
      mem_rd(A_PRIO + 12'd160, d); chk("R10 priority slot 40 reads zero", d, 32'h0);

      // R7: best-source selection and ties
      set_masks(40'hFF_FFFF_FFFF, 40'h10_0000_0010);
      mem_wr(A_PRIO + 12'd16,  32'd5);
      mem_wr(A_PRIO + 12'd144, 32'd2);
      mem_wr(A_PRIO + 12'd40,  32'd3);
      mem_wr(A_PRIO + 12'd80,  32'd3);
      @(negedge clk); src_level = 40'h10_0010_0410;
      settle();
      cp_rd(4'd5, d); chk("R7 best with tie", d, 32'h800A_8024);
      mem_wr(A_PRIO + 12'd80, 32'd1);
      cp_rd(4'd5, d); chk("R7 best after priority change", d, 32'h8014_8024);
      @(negedge clk); src_level = '0;
      settle();
      cp_rd(4'd5, d); chk("R7 best with nothing active", d, 32'h0);

      // R5: wake through the idle word for a bank-1 line
      set_masks(40'h0, 40'h0);
      mem_wr(A_IDLE, 32'h2);
      @(negedge clk); src_level = 40'h02_0000_0000; core_halted = 1'b1;
      settle();
      chk("R5 wake via idle bit for line 33", {31'h0, wake_req}, 32'h1);
      chk("R5 no irq without enable", {31'h0, irq_req}, 32'h0);
      core_halted = 1'b0;
      @(negedge clk); #1 chk("R5 wake drops one edge after halt clears", {31'h0, wake_req}, 32'h0);
      mem_wr(A_IDLE, 32'h0);
      @(negedge clk); core_halted = 1'b1;
      settle();
      chk("R5 no wake when uncovered", {31'h0, wake_req}, 32'h0);
      set_masks(40'h80, 40'h0);
      @(negedge clk); src_level = 40'h80;
      settle();
      chk("R5 wake via enable", {31'h0, wake_req}, 32'h1);
      chk("R3 irq with enabled line", {31'h0, irq_req}, 32'h1);
      core_halted = 1'b0;

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule